// File: doc/BRIEF.md
# Bus Master Latency Timer Controller

This block decides how long a bus master may keep a shared parallel bus once it has begun a burst. A host-writable 8-bit limit register is copied into a down-counter at the start of every transaction. A 3-bit prescaler slows the counter so that it steps down once every eight bus clocks. The counter stops at zero and never wraps.

The controller watches the grant level and the data-phase completion strobe, and decides whether the burst must be cut short. While grant stays with this master, the burst runs to completion whatever the counter holds. Once grant has been withdrawn, the burst may continue until the counter reaches zero. After that, the next completed data phase raises a terminate request. The master then closes the transaction on that phase boundary and releases the bus. A debug output shows the live counter, and the register readback always returns the programmed limit.

Top module: `lat_timer_ctrl`

## Requirements
- R1: During and right after synchronous reset, the limit readback, the counter, the terminate request and the expired flag are all zero.
- R2: A write strobe stores the write data in the limit register, and any 8-bit value is accepted; the readback shows it from the next cycle on, and with no write strobe the readback never changes.
- R3: The edge that samples the transaction start loads the counter with the limit register value held before that edge, so a write in the same cycle reaches only the readback.
- R4: During a transaction, with the start sampled at edge 0, the counter after edge k equals the limit minus floor(k/8), clamped at zero.
- R5: The expired flag is high exactly when a transaction is open and the counter is zero, so a limit of zero reads as expired from the cycle after the start.
- R6: While grant is high, a completed data phase never raises the terminate request, even with the counter at zero.
- R7: With grant low and the counter not yet zero, a completed data phase does not raise the terminate request, and a burst-done strobe closes the transaction without one.
- R8: With grant low and the counter at zero, the edge that samples a data-phase completion during an open transaction raises the terminate request for the following cycle.
- R9: The terminate request stays high until the edge that samples burst-done, and from the next cycle on the terminate request and the expired flag are both low.
- R10: With no transaction open, data-phase strobes and the grant level have no effect: the terminate request and the expired flag stay low.
- R11: A register write during an open transaction leaves the running counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_start | input | 1 | One-cycle pulse in the cycle the master begins a transaction |
| phase_done | input | 1 | One-cycle pulse for each completed data phase |
| burst_done | input | 1 | One-cycle pulse when the transaction finishes |
| gnt | input | 1 | Grant level; high while the arbiter grants the bus to this master |
| reg_wr_en | input | 1 | Write strobe for the limit register |
| reg_wr_data | input | 8 | Value to store in the limit register |
| reg_rd_data | output | 8 | Programmed limit (readback) |
| term_req | output | 1 | Request to end the burst on the current data-phase boundary |
| expired | output | 1 | Open transaction whose counter has reached zero |
| count_dbg | output | 8 | Live value of the down-counter |

## Verification
The assertions assume that every input is synchronous to the clock and never unknown. They also assume that xfer_start, phase_done and burst_done arrive as single-cycle pulses, and that burst_done is sent only after a transaction has been opened. Grant is treated as a level that may change on any cycle. The bench drives every input on the falling edge and opens each transaction before it closes it. It pulses each strobe for exactly one rising edge, so the stimulus stays within what the properties take as given.

// File: rtl/lat_timer_pkg.sv
package lat_timer_pkg;

  // Life cycle of one bus transaction as seen by the controller.
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_RUN  = 2'd1,
    TX_TERM = 2'd2
  } txn_state_e;

endpackage

// File: rtl/lat_timer_reg.sv
module lat_timer_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (wr_en) begin
      value <= wr_data;
    end
  end

  // Without a write strobe the readback must not move.
  assert_reg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(value));

endmodule

// File: rtl/lat_timer_presc.sv
module lat_timer_presc #(
  parameter int PW = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run && (phase_q == {PW{1'b1}});

  // The prescaler moves only while a transaction is open.
  assert_presc_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(phase_q));

endmodule

// File: rtl/lat_timer_count.sv
module lat_timer_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         zero
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (step && (count != '0)) begin
      count <= count - ONE;
    end
  end

  assign zero = (count == '0);

  // Apart from a load the counter never rises.
  assert_count_no_rise_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count <= $past(count)));

  // Apart from a load it falls by at most one per cycle.
  assert_count_one_step_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> (($past(count) - count) <= ONE));

  // With no load and no prescaler tick it stays put.
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(count));

endmodule

// File: rtl/lat_timer_ctrl.sv
module lat_timer_ctrl #(
  parameter int CNT_W   = 8,
  parameter int PRESC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_start,
  input  logic             phase_done,
  input  logic             burst_done,
  input  logic             gnt,
  input  logic             reg_wr_en,
  input  logic [CNT_W-1:0] reg_wr_data,
  output logic [CNT_W-1:0] reg_rd_data,
  output logic             term_req,
  output logic             expired,
  output logic [CNT_W-1:0] count_dbg
);

  import lat_timer_pkg::*;

  txn_state_e       state_q, state_d;
  logic             open_txn;
  logic             tick;
  logic             cnt_zero;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;

  lat_timer_reg #(.W(CNT_W)) limit_reg_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .value   (limit)
  );

  lat_timer_presc #(.PW(PRESC_W)) presc_i (
    .clk   (clk),
    .rst   (rst),
    .clear (xfer_start),
    .run   (open_txn),
    .tick  (tick)
  );

  lat_timer_count #(.W(CNT_W)) count_i (
    .clk      (clk),
    .rst      (rst),
    .load     (xfer_start),
    .load_val (limit),
    .step     (tick),
    .count    (cnt),
    .zero     (cnt_zero)
  );

  assign open_txn = (state_q != TX_IDLE);

  always_comb begin
    state_d = state_q;
    if (xfer_start) begin
      state_d = TX_RUN;
    end else begin
      unique case (state_q)
        TX_RUN: begin
          if (burst_done) begin
            state_d = TX_IDLE;
          end else if (phase_done && !gnt && cnt_zero) begin
            state_d = TX_TERM;
          end
        end
        TX_TERM: begin
          if (burst_done) begin
            state_d = TX_IDLE;
          end
        end
        default: state_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign term_req    = (state_q == TX_TERM);
  assign expired     = open_txn && cnt_zero;
  assign reg_rd_data = limit;
  assign count_dbg   = cnt;

  // A terminate request needs a completed phase, a lost grant and an expired timer.
  assert_term_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(term_req) |-> ($past(phase_done) && !$past(gnt) && $past(expired)));

  // While grant is held no terminate request can appear.
  assert_grant_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (!term_req && gnt) |=> !term_req);

  // The request is withdrawn only when the transaction ends or restarts.
  assert_term_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(term_req) |-> ($past(burst_done) || $past(xfer_start)));

  // After the transaction closes nothing stays flagged.
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (burst_done && !xfer_start) |=> (!expired && !term_req));

  // A start loads the counter with the limit held before the edge.
  assert_start_load_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> (count_dbg == $past(reg_rd_data)));

  // A limit of zero shows as expired in the cycle after the start.
  assert_zero_limit_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && (reg_rd_data == '0)) |=> expired);

endmodule

// File: tb/lat_timer_ctrl_tb_top.sv
module lat_timer_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst;
  logic       xfer_start, phase_done, burst_done, gnt, reg_wr_en;
  logic [7:0] reg_wr_data;
  logic [7:0] reg_rd_data, count_dbg;
  logic       term_req, expired;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lat_timer_ctrl dut_i (
    .clk         (clk),
    .rst         (rst),
    .xfer_start  (xfer_start),
    .phase_done  (phase_done),
    .burst_done  (burst_done),
    .gnt         (gnt),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .term_req    (term_req),
    .expired     (expired),
    .count_dbg   (count_dbg)
  );

  // Vectors: programmed limit, grant level, idle cycles before the phase strobe.
  localparam int NV = 10;
  localparam int V_LAT [NV] = '{0, 0, 1, 1, 2, 2, 3, 5, 255, 4};
  localparam int V_GNT [NV] = '{0, 1, 0, 0, 0, 0, 1, 0, 0,   0};
  localparam int V_WT  [NV] = '{0, 0, 7, 8, 15, 16, 40, 3, 20, 100};

  task automatic check_eq(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_limit(input int v);
    reg_wr_en = 1'b1;
    reg_wr_data = 8'(v);
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    xfer_start = 1'b1;
    step();
    xfer_start = 1'b0;
  endtask

  task automatic pulse_phase();
    phase_done = 1'b1;
    step();
    phase_done = 1'b0;
  endtask

  task automatic pulse_done();
    burst_done = 1'b1;
    step();
    burst_done = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    xfer_start = 1'b0; phase_done = 1'b0; burst_done = 1'b0;
    gnt = 1'b0; reg_wr_en = 1'b0; reg_wr_data = 8'h00;
    @(negedge clk);
    step();
    step();
    // R1: state right after reset
    check_eq("R1 readback", int'(reg_rd_data), 0);
    check_eq("R1 counter", int'(count_dbg), 0);
    check_eq("R1 term_req", int'(term_req), 0);
    check_eq("R1 expired", int'(expired), 0);
    rst = 1'b0;
    step();
    check_eq("R1 after release", int'({term_req, expired}), 0);

    // R2: any value can be stored and read back
    write_limit(8'hA5);
    check_eq("R2 readback A5", int'(reg_rd_data), 165);
    step();
    check_eq("R2 hold", int'(reg_rd_data), 165);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      int lat, g, w, m, exp_cnt;
      bit exp_term;
      lat = V_LAT[i]; g = V_GNT[i]; w = V_WT[i];
      write_limit(lat);
      check_eq("R2 table readback", int'(reg_rd_data), lat);
      gnt = g[0];
      pulse_start();
      check_eq("R3 load", int'(count_dbg), lat);
      check_eq("R5 expired after load", int'(expired), (lat == 0) ? 1 : 0);
      repeat (w) step();
      pulse_phase();
      m = w + 1;
      exp_cnt = lat - m / 8;
      if (exp_cnt < 0) exp_cnt = 0;
      exp_term = (g == 0) && (lat <= w / 8);
      check_eq("R4 count at phase", int'(count_dbg), exp_cnt);
      if (g != 0)
        check_eq("R6 grant held", int'(term_req), 0);
      else if (exp_term)
        check_eq("R8 expired terminate", int'(term_req), 1);
      else
        check_eq("R7 unexpired no terminate", int'(term_req), 0);
      pulse_done();
      check_eq("R9 closed", int'({term_req, expired}), 0);
      gnt = 1'b0;
    end

    // R9: terminate request persists until burst-done
    write_limit(0);
    pulse_start();
    pulse_phase();
    check_eq("R9 term raised", int'(term_req), 1);
    repeat (3) step();
    check_eq("R9 term held", int'(term_req), 1);
    pulse_done();
    check_eq("R9 term cleared", int'(term_req), 0);

    // R6 then R8: grant held blocks, loss of grant then terminates
    gnt = 1'b1;
    pulse_start();
    repeat (3) pulse_phase();
    check_eq("R6 repeated phases", int'(term_req), 0);
    gnt = 1'b0;
    pulse_phase();
    check_eq("R8 after grant loss", int'(term_req), 1);
    pulse_done();

    // R7: unexpired burst ends normally
    write_limit(10);
    pulse_start();
    repeat (5) pulse_phase();
    check_eq("R7 no terminate", int'(term_req), 0);
    pulse_done();
    check_eq("R7 normal end", int'({term_req, expired}), 0);

    // R11: write during an open transaction
    write_limit(200);
    pulse_start();
    step();
    step();
    write_limit(5);
    check_eq("R11 counter kept", int'(count_dbg), 200);
    check_eq("R11 readback new", int'(reg_rd_data), 5);
    pulse_done();

    // R3: write in the same cycle as start
    write_limit(9);
    reg_wr_en = 1'b1; reg_wr_data = 8'd50; xfer_start = 1'b1;
    step();
    reg_wr_en = 1'b0; xfer_start = 1'b0;
    check_eq("R3 old value loaded", int'(count_dbg), 9);
    check_eq("R3 readback new", int'(reg_rd_data), 50);
    pulse_done();

    // R4: counter saturates at zero
    write_limit(1);
    gnt = 1'b1;
    pulse_start();
    repeat (30) step();
    check_eq("R4 saturate", int'(count_dbg), 0);
    check_eq("R5 expired at zero", int'(expired), 1);
    pulse_done();
    gnt = 1'b0;

    // R10: strobes while idle are ignored
    write_limit(0);
    pulse_phase();
    pulse_phase();
    check_eq("R10 idle term", int'(term_req), 0);
    check_eq("R10 idle expired", int'(expired), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule